// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges four internal reset requests into a single synchronous system reset and keeps a small status byte that tells software which request caused the most recent reset. The four requests are a supply monitor driven by a comparator output, an expiry pulse from the watchdog counter, a detector of illegal program-memory accesses, and a software-forced reset. The supply-monitor request must first be armed through the status byte, and the same bit later reports whether that request caused the reset.

The access detector compares each memory access with the last address of user code space, a parameter that defaults to 0x1DFF. It raises a request when a flash write or erase, a code-space data read or an instruction fetch goes above that limit. It also raises one whenever the security logic reports a blocked access. The block also supplies the divide-by-twelve count enable for the watchdog. That count enable restarts after every reset. The block never drives the external reset pin. That pin reaches the block only as its asynchronous power-on input.

Top module: `reset_hub`

## Requirements
- R1: While `rstPinN` is low, `sysRst` is 0, `causeFlags` reads 0x00 and `wdogTick` is 0.
- R2: Writing `regWrData[5]`=1 arms the comparator source, and writing it as 0 disarms it. While armed and out of reset, `cmpOut`=0 asserts `sysRst` at the next clock edge and sets flag bit 5. While disarmed, `cmpOut`=0 has no effect.
- R3: A register write with `regWrData[4]`=1 asserts `sysRst` at the next clock edge, and flag bit 4 then reads 1.
- R4: `memKind` encodes 2'b00 as a data-space flash write or erase, 2'b01 as a code-space data read, 2'b10 as an instruction fetch and 2'b11 as no access. With `memValid`=1 and `memAddr` above 0x1DFF, kinds 2'b01 and 2'b10 cause a reset with flag bit 6, and so does kind 2'b00 when `flashWrEn`=1. An address of 0x1DFF or below, a kind 2'b00 access with `flashWrEn`=0, and kind 2'b11 all cause no reset.
- R5: `secViolation`=1 causes a reset with flag bit 6.
- R6: `wdogExpire`=1 causes a reset with flag bit 3.
- R7: `sysRst` stays high for exactly 16 clock cycles and then falls on a clock edge.
- R8: The cause is latched on the edge where `sysRst` rises. Exactly one of flag bits 6..3 is then set and the others are cleared, so bit 5 reads 1 only after a comparator reset. Bit 5 stays armed after a comparator reset, so a comparator output that is still low starts another reset right after release.
- R9: When several requests arrive in the same cycle, the highest flag bit wins: bit 6 over bit 5 over bit 4 over bit 3.
- R10: While `sysRst` is high, all requests and register writes are ignored: the flags do not change and the reset is not extended.
- R11: `wdogTick` is 0 during reset. After release it pulses for one cycle every 12 cycles, and the first pulse falls in the 12th cycle after release.
- R12: Flag bits 7, 2, 1 and 0 always read 0, and writes to any bit other than 5 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstPinN | input | 1 | Asynchronous power-on/pin reset, active low |
| cmpOut | input | 1 | Supply comparator output, low means supply fault |
| wdogExpire | input | 1 | Watchdog expiry pulse |
| memValid | input | 1 | A memory access is presented this cycle |
| memKind | input | 2 | Access type: 00 flash write, 01 code read, 10 fetch, 11 none |
| memAddr | input | 16 | Access address |
| flashWrEn | input | 1 | Flash write/erase enable control |
| secViolation | input | 1 | Access blocked by the security setting |
| regWrEn | input | 1 | Status register write strobe |
| regWrData | input | 8 | Status register write data |
| sysRst | output | 1 | Synchronous internal system reset, active high |
| causeFlags | output | 8 | Reset-cause status byte |
| wdogTick | output | 1 | Watchdog count enable, one pulse every 12 cycles |

## Verification
The checker tests the following on every cycle: each reset lasts exactly the hold length, exactly one cause flag is set when the reset rises, the flags stay frozen during the hold, and no count pulse appears while in reset. It also checks that a watchdog, software, armed-comparator or out-of-range fetch request is followed by reset on the next edge, and that the unused flag bits read 0. Only the bench scenarios can show the full address decode, including the addresses exactly at the limit and the flash write with the enable off. The same holds for the priority among simultaneous requests, the disarming of the comparator, a second reset when the comparator stays low, and the 12-cycle phase of the count pulse after release.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int NUM_SRC  = 4;
  localparam int FLAG_LSB = 3;     // cause flags occupy status bits 6..3
  localparam int SW_BIT   = 4;
  localparam int CMP_BIT  = 5;
  // request/cause vector index, ordered by priority (highest index wins)
  localparam int IDX_WDT   = 0;
  localparam int IDX_SW    = 1;
  localparam int IDX_CMP   = 2;
  localparam int IDX_FLASH = 3;

  typedef enum logic [1:0] {
    KIND_DATA_WR = 2'b00,
    KIND_CODE_RD = 2'b01,
    KIND_FETCH   = 2'b10,
    KIND_NONE    = 2'b11
  } memKind_e;

  typedef struct packed {
    logic               fire;
    logic [NUM_SRC-1:0] cause;
  } rstStrobe_t;
endpackage

// File: rtl/reset_hub_dp.sv
module reset_hub_dp
  import reset_hub_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] USER_TOP = 16'h1DFF,
  parameter int PRESCALE = 12
) (
  input  logic               clk,
  input  logic               rstPinN,
  input  logic               inReset,
  input  rstStrobe_t         strobe,
  input  logic               cmpOut,
  input  logic               wdogExpire,
  input  logic               memValid,
  input  logic [1:0]         memKind,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic               flashWrEn,
  input  logic               secViolation,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  output logic [NUM_SRC-1:0] reqVec,
  output logic [7:0]         causeFlags,
  output logic               wdogTick
);
  localparam int PRE_W = $clog2(PRESCALE);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [NUM_SRC-1:0] flagQ;
  logic [PRE_W-1:0]   preCnt;
  logic               aboveUser;
  logic               badAccess;
  logic               unusedWrBits;

  assign unusedWrBits = ^{regWrData[7:6], regWrData[3:0]};
  assign aboveUser = memAddr > USER_TOP;

  always_comb begin
    badAccess = 1'b0;
    if (memValid && aboveUser) begin
      case (memKind_e'(memKind))
        KIND_DATA_WR: badAccess = flashWrEn;
        KIND_CODE_RD: badAccess = 1'b1;
        KIND_FETCH:   badAccess = 1'b1;
        default:      badAccess = 1'b0;
      endcase
    end
  end

  always_comb begin
    reqVec            = '0;
    reqVec[IDX_FLASH] = badAccess | secViolation;
    reqVec[IDX_CMP]   = flagQ[IDX_CMP] & ~cmpOut;
    reqVec[IDX_SW]    = regWrEn & regWrData[SW_BIT];
    reqVec[IDX_WDT]   = wdogExpire;
  end

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      flagQ <= '0;
    end else if (strobe.fire) begin
      flagQ <= strobe.cause;
    end else if (regWrEn && !inReset) begin
      flagQ[IDX_CMP] <= regWrData[CMP_BIT];
    end
  end

  always_comb begin
    causeFlags = '0;
    causeFlags[FLAG_LSB +: NUM_SRC] = flagQ;
  end

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      preCnt <= '0;
    end else if (inReset || preCnt == PRE_LAST) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign wdogTick = !inReset && (preCnt == PRE_LAST);
endmodule

// File: rtl/reset_hub_ctrl.sv
module reset_hub_ctrl
  import reset_hub_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstPinN,
  input  logic [NUM_SRC-1:0] reqVec,
  output logic               sysRst,
  output rstStrobe_t         strobe
);
  localparam int CNT_W = $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0]   holdCnt;
  logic               rstQ;
  logic [NUM_SRC-1:0] winner;
  logic               found;

  // priority pick: highest index wins
  always_comb begin
    winner = '0;
    found  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i] && !found) begin
        winner[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign strobe.fire  = !rstQ && found;
  assign strobe.cause = winner;

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      rstQ    <= 1'b0;
      holdCnt <= '0;
    end else if (strobe.fire) begin
      rstQ    <= 1'b1;
      holdCnt <= HOLD_LOAD;
    end else if (rstQ) begin
      if (holdCnt == '0) begin
        rstQ <= 1'b0;
      end else begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  assign sysRst = rstQ;
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] USER_TOP = 16'h1DFF,
  parameter int HOLD_CYCLES = 16,
  parameter int PRESCALE = 12
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              cmpOut,
  input  logic              wdogExpire,
  input  logic              memValid,
  input  logic [1:0]        memKind,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              flashWrEn,
  input  logic              secViolation,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic              sysRst,
  output logic [7:0]        causeFlags,
  output logic              wdogTick
);
  logic [NUM_SRC-1:0] reqVec;
  rstStrobe_t         strobe;

  reset_hub_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstPinN (rstPinN),
    .reqVec  (reqVec),
    .sysRst  (sysRst),
    .strobe  (strobe)
  );

  reset_hub_dp #(
    .ADDR_W   (ADDR_W),
    .USER_TOP (USER_TOP),
    .PRESCALE (PRESCALE)
  ) u_dp (
    .clk          (clk),
    .rstPinN      (rstPinN),
    .inReset      (sysRst),
    .strobe       (strobe),
    .cmpOut       (cmpOut),
    .wdogExpire   (wdogExpire),
    .memValid     (memValid),
    .memKind      (memKind),
    .memAddr      (memAddr),
    .flashWrEn    (flashWrEn),
    .secViolation (secViolation),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .reqVec       (reqVec),
    .causeFlags   (causeFlags),
    .wdogTick     (wdogTick)
  );
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] USER_TOP = 16'h1DFF,
  parameter int HOLD_CYCLES = 16
) (
  input logic              clk,
  input logic              rstPinN,
  input logic              sysRst,
  input logic [7:0]        causeFlags,
  input logic              wdogTick,
  input logic              wdogExpire,
  input logic              regWrEn,
  input logic              swBit,
  input logic              cmpOut,
  input logic              memValid,
  input logic [1:0]        memKind,
  input logic [ADDR_W-1:0] memAddr
);
  localparam int RUN_W = $clog2(HOLD_CYCLES + 1) + 1;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) runLen <= '0;
    else if (sysRst) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  assert_hold_length_R7: assert property (@(posedge clk) disable iff (!rstPinN)
    $fell(sysRst) |-> runLen == RUN_W'(HOLD_CYCLES));

  assert_hold_bound_R7: assert property (@(posedge clk) disable iff (!rstPinN)
    sysRst |-> runLen < RUN_W'(HOLD_CYCLES));

  assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rstPinN)
    $rose(sysRst) |-> $countones(causeFlags[6:3]) == 1);

  assert_frozen_flags_R10: assert property (@(posedge clk) disable iff (!rstPinN)
    sysRst && $past(sysRst) |-> $stable(causeFlags));

  assert_no_tick_in_reset_R11: assert property (@(posedge clk) disable iff (!rstPinN)
    sysRst |-> !wdogTick);

  assert_wdog_resets_R6: assert property (@(posedge clk) disable iff (!rstPinN)
    !sysRst && wdogExpire |=> sysRst);

  assert_sw_resets_R3: assert property (@(posedge clk) disable iff (!rstPinN)
    !sysRst && regWrEn && swBit |=> sysRst);

  assert_cmp_resets_R2: assert property (@(posedge clk) disable iff (!rstPinN)
    !sysRst && causeFlags[5] && !cmpOut |=> sysRst);

  assert_bad_fetch_R4: assert property (@(posedge clk) disable iff (!rstPinN)
    !sysRst && memValid && memKind == 2'b10 && memAddr > USER_TOP |=> sysRst && causeFlags[6]);

  assert_spare_bits_R12: assert property (@(posedge clk) disable iff (!rstPinN)
    causeFlags[7] == 1'b0 && causeFlags[2:0] == 3'b000);
endmodule

bind reset_hub reset_hub_chk #(
  .ADDR_W      (ADDR_W),
  .USER_TOP    (USER_TOP),
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk        (clk),
  .rstPinN    (rstPinN),
  .sysRst     (sysRst),
  .causeFlags (causeFlags),
  .wdogTick   (wdogTick),
  .wdogExpire (wdogExpire),
  .regWrEn    (regWrEn),
  .swBit      (regWrData[4]),
  .cmpOut     (cmpOut),
  .memValid   (memValid),
  .memKind    (memKind),
  .memAddr    (memAddr)
);

// File: tb/test_reset_hub.sv
module test_reset_hub;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;

  logic        clk = 1'b0;
  logic        rstPinN = 1'b0;
  logic        cmpOut, wdogExpire, memValid, flashWrEn, secViolation, regWrEn;
  logic [1:0]  memKind;
  logic [15:0] memAddr;
  logic [7:0]  regWrData;
  logic        sysRst, wdogTick;
  logic [7:0]  causeFlags;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  reset_hub i_reset_hub (
    .clk (clk), .rstPinN (rstPinN), .cmpOut (cmpOut), .wdogExpire (wdogExpire),
    .memValid (memValid), .memKind (memKind), .memAddr (memAddr),
    .flashWrEn (flashWrEn), .secViolation (secViolation), .regWrEn (regWrEn),
    .regWrData (regWrData), .sysRst (sysRst), .causeFlags (causeFlags),
    .wdogTick (wdogTick)
  );

  typedef struct packed {
    logic        arm;
    logic        valid;
    logic [1:0]  kind;
    logic [15:0] addr;
    logic        fwe;
    logic        sec;
    logic        cmpLow;
    logic        wdog;
    logic        sw;
    logic        expFire;
    logic [7:0]  expFlags;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 2'd2, 16'h1E00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h40, 4'd4}, // R4 fetch above
    '{1'b0, 1'b1, 2'd2, 16'h1DFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd4}, // R4 fetch at limit
    '{1'b0, 1'b1, 2'd1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h40, 4'd4}, // R4 code read above
    '{1'b0, 1'b1, 2'd1, 16'h1DFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd4}, // R4 code read at limit
    '{1'b0, 1'b1, 2'd0, 16'h1E00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h40, 4'd4}, // R4 flash write above
    '{1'b0, 1'b1, 2'd0, 16'h1E00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd4}, // R4 write, enable off
    '{1'b0, 1'b1, 2'd0, 16'h1DFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd4}, // R4 write at limit
    '{1'b0, 1'b1, 2'd3, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd4}, // R4 no-access kind
    '{1'b0, 1'b0, 2'd3, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h40, 4'd5}, // R5 security
    '{1'b0, 1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h08, 4'd6}, // R6 watchdog
    '{1'b0, 1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 4'd3}, // R3 software
    '{1'b0, 1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2}, // R2 disarmed
    '{1'b1, 1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h20, 4'd2}, // R2 armed, low
    '{1'b1, 1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h08, 4'd8}, // R8 clears bit 5
    '{1'b1, 1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h20, 4'd9}, // R9 cmp wins
    '{1'b1, 1'b1, 2'd2, 16'h1E00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h40, 4'd9}, // R9 flash wins
    '{1'b0, 1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h10, 4'd9}, // R9 sw over wdog
    '{1'b1, 1'b0, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20, 4'd2}  // R2 armed, idle
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic setIdle();
    memValid = 1'b0; memKind = 2'd3; memAddr = '0; flashWrEn = 1'b0;
    secViolation = 1'b0; cmpOut = 1'b1; wdogExpire = 1'b0;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pinReset();
    rstPinN = 1'b0;
    @(negedge clk);
    rstPinN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic waitRelease(output int n);
    n = 0;
    while (sysRst === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired before the bench finished");
    report();
  end

  initial begin
    int n;
    int w;
    setIdle();
    rstPinN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: state held by the pin reset
    check("R1 sysRst", sysRst, 0);
    check("R1 flags", causeFlags, 8'h00);
    check("R1 tick", wdogTick, 0);
    rstPinN = 1'b1;
    @(negedge clk);

    // table of single-cycle stimuli
    for (int i = 0; i < NV; i++) begin
      pinReset();
      if (VEC[i].arm) writeReg(8'h20);
      memValid = VEC[i].valid; memKind = VEC[i].kind; memAddr = VEC[i].addr;
      flashWrEn = VEC[i].fwe; secViolation = VEC[i].sec; cmpOut = !VEC[i].cmpLow;
      wdogExpire = VEC[i].wdog;
      if (VEC[i].sw) begin regWrEn = 1'b1; regWrData = 8'h10; end
      @(negedge clk);
      setIdle();
      check(reqName(VEC[i].req), sysRst, VEC[i].expFire);
      check(reqName(VEC[i].req), causeFlags, VEC[i].expFlags);
      if (VEC[i].expFire) begin
        waitRelease(n);
        check("R7 hold length", n, HOLD);
      end
    end

    // R11: count-enable phase after release
    pinReset();
    writeReg(8'h10);
    waitRelease(n);
    w = 0;
    while (wdogTick !== 1'b1 && w < 40) begin @(negedge clk); w++; end
    check("R11 first tick", w, 11);
    w = 0;
    do begin @(negedge clk); w++; end while (wdogTick !== 1'b1 && w < 40);
    check("R11 tick spacing", w, 12);

    // R10: requests and writes during the hold are ignored
    pinReset();
    regWrEn = 1'b1; regWrData = 8'h10;
    @(negedge clk);
    setIdle();
    check("R10 in reset", sysRst, 1);
    wdogExpire = 1'b1; secViolation = 1'b1; regWrEn = 1'b1; regWrData = 8'h20;
    memValid = 1'b1; memKind = 2'd2; memAddr = 16'hFFFF;
    @(negedge clk);
    setIdle();
    waitRelease(n);
    check("R10 not extended", n + 1, HOLD);
    check("R10 flags kept", causeFlags, 8'h10);
    @(negedge clk);
    check("R10 no late reset", sysRst, 0);

    // R8: comparator stays armed and retriggers while low
    pinReset();
    writeReg(8'h20);
    cmpOut = 1'b0;
    @(negedge clk);
    check("R8 cmp reset", causeFlags, 8'h20);
    waitRelease(n);
    check("R8 released", sysRst, 0);
    @(negedge clk);
    check("R8 retrigger", sysRst, 1);
    check("R8 cause again", causeFlags, 8'h20);
    cmpOut = 1'b1;
    waitRelease(n);

    // R2: disarming the comparator
    pinReset();
    writeReg(8'h20);
    writeReg(8'h00);
    check("R2 disarmed flags", causeFlags, 8'h00);
    cmpOut = 1'b0;
    @(negedge clk);
    check("R2 disarmed no reset", sysRst, 0);
    cmpOut = 1'b1;

    // R12: only bit 5 is writable, spare bits read zero
    pinReset();
    writeReg(8'hEF);
    check("R12 write mask", causeFlags, 8'h20);
    check("R12 no reset", sysRst, 0);

    report();
  end
endmodule